// File: doc/BRIEF.md
# Receive Queue with Per-Character Error Tags and Line Status

This block buffers received serial characters for a CPU and summarises the state of the serial link in one 8-bit status word. A character arrives from the serial receiver together with three tags: parity fault, framing fault and break. The block stores the character and its tags as one entry in a first-in first-out queue that holds `DEPTH` entries. The CPU removes the oldest entry with a pop handshake. The status word always describes the entry at the head of the queue, so the CPU sees each error flag next to the byte it belongs to.

The receive push side has no back-pressure. The receiver cannot be stalled, so `rx_valid` is a one-cycle strobe and has no ready signal. A character that arrives while the queue is full is dropped and recorded as an overrun. The pop side follows valid/ready rules: `rd_valid` is high while the queue holds data, `rd_data` shows the head byte, and an entry leaves on a clock edge where both `rd_valid` and `rd_ready` are high. `rd_ready` has no effect while the queue is empty. A continuous break is stored only once. Further break strobes are ignored until the receiver reports that the line has returned high. Two transmit-side inputs are passed through into the transmit-empty bits of the status word.

Top module: `uart_rx_status`

## Requirements
- R1: Status bit 0 and `rd_valid` are 1 exactly when the queue holds at least one entry. A pop with `rd_ready` high while the queue is empty has no effect.
- R2: Entries leave in arrival order, and `rd_data` shows the byte of the oldest entry.
- R3: When a character that is not suppressed arrives while the queue is full and no pop happens in the same cycle, the character is discarded, the stored entries stay unchanged, and status bit 1 (overrun) is 1 from the next cycle.
- R4: Status bit 1 stays set until a cycle with `lsr_rd` high and then reads 0. If a new overrun happens in that same cycle, the bit stays 1.
- R5: Status bit 2 is the parity tag and status bit 3 is the framing tag of the head entry. Both bits are 0 when the queue is empty.
- R6: Status bit 4 is the break tag of the head entry. When several break strobes arrive with no line-high indication between them, only the first is stored.
- R7: After a stored break, a pulse on `rx_line_high` re-arms break storage, so the next break strobe is stored as a new entry.
- R8: Status bit 5 equals `tx_fifo_empty`.
- R9: Status bit 6 is 1 only when both `tx_fifo_empty` and `tx_shift_empty` are 1.
- R10: Status bit 7 sets when an entry that carries any tag is stored. It stays set until a status read. After the read it becomes 0, unless tagged entries are still in the queue once the read cycle ends, in which case it stays 1.
- R11: A push and a pop in the same cycle on a full queue are both accepted and do not set overrun.
- R12: After reset the queue is empty, and status bits 0 to 4 and bit 7 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity fault tag for the character |
| rx_ferr | input | 1 | Framing fault tag for the character |
| rx_brk | input | 1 | Character is a break frame |
| rx_line_high | input | 1 | Receiver saw the line high (re-arms break storage) |
| rd_ready | input | 1 | CPU takes the head entry |
| rd_valid | output | 1 | Queue holds at least one entry |
| rd_data | output | 8 | Byte of the head entry |
| lsr_rd | input | 1 | Status word is being read (clears sticky bits) |
| tx_fifo_empty | input | 1 | Transmit queue is empty |
| tx_shift_empty | input | 1 | Transmit shifter is idle |
| lsr | output | 8 | Line status word |

## Verification
The bench builds the block with `DEPTH` = 4. With that depth, a full queue, pointer wrap-around and overrun are reached after only a few pushes. Directed sequences hit each corner: an overrun in the same cycle as a status read, a swap on a full queue, repeated break strobes before and after re-arming, and a status read while tagged entries remain. After these, an arithmetic stimulus sweep of several hundred cycles mixes pushes, pops, tags, breaks and status reads across many wrap-arounds. A queue model in the bench predicts every status bit and the head byte in every cycle.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;
  parameter int unsigned RXS_DATA_W = 8;

  typedef struct packed {
    logic                  brk;
    logic                  ferr;
    logic                  perr;
    logic [RXS_DATA_W-1:0] data;
  } rxs_entry_t;

  function automatic logic entry_tagged(input rxs_entry_t e);
    return e.brk | e.ferr | e.perr;
  endfunction
endpackage

// File: rtl/rxs_brk_gate.sv
module rxs_brk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_brk,
  input  logic line_high,
  output logic out_valid
);
  logic armed;
  logic take_brk;

  assign take_brk  = in_valid & in_brk & armed;
  assign out_valid = in_valid & (~in_brk | armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b1;
    else if (take_brk)  armed <= 1'b0;
    else if (line_high) armed <= 1'b1;
  end
endmodule

// File: rtl/rxs_tag_fifo.sv
module rxs_tag_fifo
  import uart_rxs_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  rxs_entry_t wr_entry,
  input  logic       pop,
  output rxs_entry_t head,
  output logic       empty,
  output logic       full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  rxs_entry_t       slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign head  = slots[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 slots[i] <= '0;
      else if (push && wr_ptr == PTR_W'(i))       slots[i] <= wr_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxs_lsr_flags.sv
module rxs_lsr_flags #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_tagged,
  input  logic pop,
  input  logic head_tagged,
  input  logic ovr_evt,
  input  logic status_rd,
  output logic oe_flag,
  output logic err_flag
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] tag_cnt, tag_cnt_nxt;
  logic             add_tag, drop_tag;

  assign add_tag     = push & push_tagged;
  assign drop_tag    = pop & head_tagged;
  assign tag_cnt_nxt = tag_cnt + CNT_W'(add_tag) - CNT_W'(drop_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_cnt  <= '0;
      oe_flag  <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      tag_cnt <= tag_cnt_nxt;
      oe_flag <= (oe_flag & ~status_rd) | ovr_evt;
      if (status_rd) err_flag <= (tag_cnt_nxt != '0);
      else           err_flag <= err_flag | add_tag;
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rxs_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  input  logic [RXS_DATA_W-1:0] rx_data,
  input  logic                  rx_perr,
  input  logic                  rx_ferr,
  input  logic                  rx_brk,
  input  logic                  rx_line_high,
  input  logic                  rd_ready,
  output logic                  rd_valid,
  output logic [RXS_DATA_W-1:0] rd_data,
  input  logic                  lsr_rd,
  input  logic                  tx_fifo_empty,
  input  logic                  tx_shift_empty,
  output logic [7:0]            lsr
);
  logic       ch_valid;
  logic       fifo_empty, fifo_full;
  logic       pop_en, push_en, ovr_evt;
  logic       oe_flag, err_flag;
  rxs_entry_t wr_entry, head;

  rxs_brk_gate u_brk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_valid),
    .in_brk    (rx_brk),
    .line_high (rx_line_high),
    .out_valid (ch_valid)
  );

  assign wr_entry = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};
  assign pop_en   = rd_ready & ~fifo_empty;
  assign push_en  = ch_valid & (~fifo_full | pop_en);
  assign ovr_evt  = ch_valid & fifo_full & ~pop_en;

  rxs_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_en),
    .wr_entry (wr_entry),
    .pop      (pop_en),
    .head     (head),
    .empty    (fifo_empty),
    .full     (fifo_full)
  );

  rxs_lsr_flags #(.DEPTH(DEPTH)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push_en),
    .push_tagged (entry_tagged(wr_entry)),
    .pop         (pop_en),
    .head_tagged (entry_tagged(head)),
    .ovr_evt     (ovr_evt),
    .status_rd   (lsr_rd),
    .oe_flag     (oe_flag),
    .err_flag    (err_flag)
  );

  assign rd_valid = ~fifo_empty;
  assign rd_data  = head.data;

  always_comb begin
    lsr[0] = ~fifo_empty;
    lsr[1] = oe_flag;
    lsr[2] = head.perr & ~fifo_empty;
    lsr[3] = head.ferr & ~fifo_empty;
    lsr[4] = head.brk & ~fifo_empty;
    lsr[5] = tx_fifo_empty;
    lsr[6] = tx_fifo_empty & tx_shift_empty;
    lsr[7] = err_flag;
  end
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_brk,
  input logic       rd_ready,
  input logic       rd_valid,
  input logic       lsr_rd,
  input logic       full,
  input logic [7:0] lsr
);
  // R1
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !rx_valid) |=> !rd_valid);
  // R3
  oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_brk && full && !rd_ready) |=> lsr[1]);
  // R4
  oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr[1] && !lsr_rd) |=> lsr[1]);
  // R4
  oe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid) |=> !lsr[1]);
  // R11
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rx_valid && rd_ready && !lsr[1]) |=> !lsr[1]);
  // R9
  temt_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr[7] && !lsr_rd) |=> lsr[7]);
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_valid (rx_valid),
  .rx_brk   (rx_brk),
  .rd_ready (rd_ready),
  .rd_valid (rd_valid),
  .lsr_rd   (lsr_rd),
  .full     (fifo_full),
  .lsr      (lsr)
);

// File: tb/uart_rx_status_test.sv
`timescale 1ns/1ps
module uart_rx_status_test;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0, rx_line_high = 0;
  logic [7:0] rx_data = '0;
  logic       rd_ready = 0, lsr_rd = 0;
  logic       tx_fifo_empty = 1, tx_shift_empty = 1;
  logic       rd_valid;
  logic [7:0] rd_data, lsr;

  int tests = 0, fails = 0;
  logic [10:0] q[$];
  logic m_oe = 0, m_err = 0, m_armed = 1;

  always #2.5 clk = ~clk;

  uart_rx_status #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .rx_line_high(rx_line_high), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .lsr_rd(lsr_rd), .tx_fifo_empty(tx_fifo_empty),
    .tx_shift_empty(tx_shift_empty), .lsr(lsr)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int tagged_cnt();
    int n = 0;
    foreach (q[i]) if (q[i][10:8] != 3'b000) n++;
    return n;
  endfunction

  task automatic compare_all();
    logic ne = (q.size() != 0);
    logic [10:0] h = ne ? q[0] : 11'h0;
    chk("R1 data ready", {7'b0, lsr[0]}, {7'b0, ne});
    chk("R1 rd_valid", {7'b0, rd_valid}, {7'b0, ne});
    chk("R3/R4 overrun", {7'b0, lsr[1]}, {7'b0, m_oe});
    chk("R5 parity/framing", {6'b0, lsr[3:2]}, {6'b0, h[9:8]});
    chk("R6 break", {7'b0, lsr[4]}, {7'b0, h[10]});
    chk("R8 thr empty", {7'b0, lsr[5]}, {7'b0, tx_fifo_empty});
    chk("R9 tx empty", {7'b0, lsr[6]}, {7'b0, tx_fifo_empty & tx_shift_empty});
    chk("R10 error summary", {7'b0, lsr[7]}, {7'b0, m_err});
    if (ne) chk("R2 head byte", rd_data, h[7:0]);
  endtask

  task automatic cyc(input logic v, input logic [7:0] d, input logic pe, input logic fe,
                     input logic bi, input logic line, input logic rdr, input logic lrd);
    logic ch, pop, push, ovr, full;
    rx_valid = v; rx_data = d; rx_perr = pe; rx_ferr = fe; rx_brk = bi;
    rx_line_high = line; rd_ready = rdr; lsr_rd = lrd;
    ch   = v && (!bi || m_armed);
    if (v && bi && m_armed) m_armed = 0;
    else if (line) m_armed = 1;
    full = (q.size() == DEPTH);
    pop  = rdr && q.size() != 0;
    push = ch && (!full || pop);
    ovr  = ch && full && !pop;
    if (pop) void'(q.pop_front());
    if (push) q.push_back({bi, fe, pe, d});
    m_oe = (lrd ? 1'b0 : m_oe) | ovr;
    if (lrd) m_err = (tagged_cnt() != 0);
    else     m_err = m_err | (push && (pe | fe | bi));
    @(posedge clk); #1;
    rx_valid = 0; rx_line_high = 0; rd_ready = 0; lsr_rd = 0; rx_brk = 0;
    rx_perr = 0; rx_ferr = 0;
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R12: reset state with both transmit inputs high
    chk("R12 reset status", lsr, 8'h60);
    chk("R12 reset empty", {7'b0, rd_valid}, 8'h00);

    // R8 R9: all transmit-input combinations
    for (int t = 0; t < 4; t++) begin
      tx_fifo_empty = t[0]; tx_shift_empty = t[1];
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
    end
    tx_fifo_empty = 1; tx_shift_empty = 0;

    // R1: pop on empty has no effect
    cyc(0, 0, 0, 0, 0, 0, 1, 0);

    // R2 R3 R5: overfill, tags from index bits, then drain
    for (int i = 0; i < DEPTH + 2; i++)
      cyc(1, 8'(i * 37 + 5), i[0], i[1], 0, 0, 0, 0);
    chk("R3 overrun set", {7'b0, lsr[1]}, 8'h01);
    chk("R3 head kept", rd_data, 8'd5);
    // R4: overrun in the same cycle as status read keeps flag
    cyc(1, 8'hEE, 0, 0, 0, 0, 0, 1);
    chk("R4 set wins over clear", {7'b0, lsr[1]}, 8'h01);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R4 cleared by read", {7'b0, lsr[1]}, 8'h00);
    // R11: swap on full queue
    cyc(1, 8'h77, 0, 0, 0, 0, 1, 0);
    chk("R11 no overrun on swap", {7'b0, lsr[1]}, 8'h00);
    // R10: status read with tagged entries remaining keeps bit 7
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R10 reasserted", {7'b0, lsr[7]}, 8'h01);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R10 sticky after drain", {7'b0, lsr[7]}, 8'h01);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R10 cleared", {7'b0, lsr[7]}, 8'h00);

    // R6 R7: repeated breaks, then re-arm
    for (int i = 0; i < 3; i++) cyc(1, 8'h00, 0, 1, 1, 0, 0, 0);
    chk("R6 single break entry", {7'b0, lsr[4]}, 8'h01);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R6 only one break stored", {7'b0, rd_valid}, 8'h00);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(1, 8'h00, 0, 1, 1, 0, 0, 0);
    chk("R7 break after re-arm", {7'b0, lsr[4]}, 8'h01);
    cyc(0, 0, 0, 0, 0, 0, 1, 1);

    // Arithmetic sweep over mixed traffic
    for (int k = 0; k < 400; k++) begin
      tx_fifo_empty = k[3]; tx_shift_empty = k[4];
      cyc((k % 3) != 0, 8'(k * 13 + 1), (k % 5) == 1, (k % 7) == 2,
          (k % 11) == 3 || (k % 11) == 4, (k % 13) == 0,
          ((k / 2) % 3) == 0, (k % 9) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule